// File: doc/BRIEF.md
# I2C Burst Read Receive Controller

This block runs the data phase of an I2C master read once the addressing header has already gone out on the bus. A single start pulse loads a burst length. From then on the controller drives a bit engine one byte at a time with no help from software. Each received byte is handed downstream on a valid/ready port. The controller also chooses the acknowledge bit for every byte, and after the final byte it requests a STOP condition so the slave releases the data line.

A hardware down-counter tracks how many bytes are still owed. While that counter is above one, each byte is answered with ACK. When it reaches one, the byte is answered with NAK and a STOP command follows directly. If the downstream consumer is slow, the controller does not issue the next read command, so the bit engine keeps the clock low until the byte has been taken. An abort input cuts the burst short: the byte in progress (or the next one) is NAKed and the bus is closed with a STOP. A zero burst length is refused with an error pulse and causes no bus activity.

The bit-engine interface uses a command handshake (valid/ready, with a flag selecting a byte read or a STOP) and a one-cycle response strobe that carries the received byte. During a read command, the acknowledge choice is presented as a level that the engine samples at its acknowledge slot.

Top module: `i2c_burst_rx`

## Requirements
- R1: A start pulse in idle with a nonzero count N issues exactly N read-byte commands (`be_cmd_stop_o`=0), and the N bytes from `be_rdata_i` come out on `rx_data_o` in the order they were received.
- R2: Every byte of a burst except the last is acknowledged: `be_nak_o` is 0 when its response strobe arrives.
- R3: The last byte of a burst is not acknowledged: `be_nak_o` is 1 when its response strobe arrives.
- R4: The command that follows a NAKed byte is a STOP (`be_cmd_stop_o`=1), and exactly one STOP is issued per burst, with no read command after it.
- R5: A start pulse with a count of zero raises `err_zero_o` for exactly one cycle, in the cycle after the start. No command is issued and `busy_o` stays low.
- R6: While `rx_valid_o` is high and `rx_ready_i` is low, `rx_data_o` stays unchanged, `rx_valid_o` stays high, and no read command is requested.
- R7: `done_o` is a one-cycle pulse in the cycle right after the STOP response strobe, and `remaining_o` reads zero in that cycle.
- R8: A pulse on `abort_i` during the read phase makes the byte in progress (or the next byte, if none is in flight) a NAK. A STOP and `done_o` follow, and no more than N bytes are read. An abort during the first command slot yields exactly one byte.
- R9: During reset and right after it, all command, data-valid, busy, done and error outputs are 0 and `remaining_o` is 0.
- R10: A start pulse while a burst is in progress is ignored: the burst length is still the count loaded at the first start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a burst (honoured only when idle) |
| count_i | input | CNT_W | Burst length, sampled with start_i |
| abort_i | input | 1 | Cut the burst short with NAK then STOP |
| be_cmd_valid_o | output | 1 | Command request to the bit engine |
| be_cmd_stop_o | output | 1 | 1 = STOP command, 0 = read one byte |
| be_nak_o | output | 1 | Acknowledge level for the current read: 1 = NAK, 0 = ACK |
| be_cmd_ready_i | input | 1 | Bit engine accepts the command |
| be_resp_valid_i | input | 1 | One-cycle strobe: the accepted command has finished |
| be_rdata_i | input | DATA_W | Received byte, valid with a read response |
| rx_data_o | output | DATA_W | Byte to the consumer |
| rx_valid_o | output | 1 | rx_data_o holds a byte |
| rx_ready_i | input | 1 | Consumer takes the byte |
| busy_o | output | 1 | A burst is in progress |
| done_o | output | 1 | One-cycle pulse after the closing STOP |
| err_zero_o | output | 1 | One-cycle pulse after a zero-count start |
| remaining_o | output | CNT_W | Bytes still owed in the current burst |

## Verification
The bench mixes random burst lengths, consumer back-pressure and bit-engine latencies with directed corner cases. These cover a one-byte burst, a long burst, a zero count, an abort in the very first command slot, a heavily stalled consumer, and a second start during a burst. A design with an off-by-one counter would NAK one byte early or late, which shows up in the recorded acknowledge history. A design that ignores back-pressure would request a read while a byte is still unread, or would change the held byte. A design that mishandles the ending would either omit the STOP or issue a read after the NAK, or it would place `done_o` in the wrong cycle or with a nonzero remaining count.

// File: rtl/i2cbr_pkg.sv
package i2cbr_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD_ISSUE,
      ST_RD_WAIT,
      ST_STOP_ISSUE,
      ST_STOP_WAIT,
      ST_FINISH
   } seq_state_t;

   function automatic logic in_read_phase(input seq_state_t s);
      return (s == ST_RD_ISSUE) || (s == ST_RD_WAIT);
   endfunction

endpackage

// File: rtl/i2cbr_counter.sv
module i2cbr_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             dec,
   input  logic             clr,
   output logic [CNT_W-1:0] count,
   output logic             is_last
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   generate
      if (CNT_W < 1) begin : g_bad_width
         $error("i2cbr_counter: CNT_W must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] count_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q <= '0;
      end else if (clr) begin
         count_q <= '0;
      end else if (load) begin
         count_q <= load_val;
      end else if (dec) begin
         count_q <= count_q - ONE;
      end
   end

   assign count   = count_q;
   assign is_last = (count_q == ONE);

   AST_CNT_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      dec |-> (count_q != '0)); // R1

endmodule

// File: rtl/i2cbr_rxbuf.sv
module i2cbr_rxbuf #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture,
   input  logic [DATA_W-1:0] cap_data,
   input  logic              ready,
   output logic              valid,
   output logic [DATA_W-1:0] data
);
   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("i2cbr_rxbuf: DATA_W must be at least 1");
      end
   endgenerate

   logic              valid_q;
   logic [DATA_W-1:0] data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         data_q  <= '0;
      end else if (capture) begin
         valid_q <= 1'b1;
         data_q  <= cap_data;
      end else if (valid_q && ready) begin
         valid_q <= 1'b0;
      end
   end

   assign valid = valid_q;
   assign data  = data_q;

   AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_q && !ready) |=> (valid_q && $stable(data_q))); // R6

   AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
      capture |-> !valid_q); // R6

endmodule

// File: rtl/i2cbr_seq.sv
module i2cbr_seq
   import i2cbr_pkg::*;
#(
   parameter bit ABORT_COMB = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic count_zero,
   input  logic abort,
   input  logic cmd_ready,
   input  logic resp_valid,
   input  logic rem_last,
   input  logic rx_full,
   output logic cnt_load,
   output logic cnt_dec,
   output logic cnt_clr,
   output logic cmd_valid,
   output logic cmd_stop,
   output logic nak,
   output logic rx_capture,
   output logic busy,
   output logic done,
   output logic err_zero
);
   seq_state_t state_q, state_d;
   logic       abort_q;
   logic       abort_now;
   logic       nak_now;
   logic       err_q;

   generate
      if (ABORT_COMB) begin : g_abort_comb
         assign abort_now = abort_q | abort;
      end else begin : g_abort_reg
         assign abort_now = abort_q;
      end
   endgenerate

   assign nak_now = rem_last | abort_now;

   always_comb begin
      state_d    = state_q;
      cnt_load   = 1'b0;
      cnt_dec    = 1'b0;
      cnt_clr    = 1'b0;
      cmd_valid  = 1'b0;
      cmd_stop   = 1'b0;
      nak        = 1'b0;
      rx_capture = 1'b0;
      done       = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (start && !count_zero) begin
               cnt_load = 1'b1;
               state_d  = ST_RD_ISSUE;
            end
         end
         ST_RD_ISSUE: begin
            cmd_valid = !rx_full;
            nak       = nak_now;
            if (!rx_full && cmd_ready) begin
               state_d = ST_RD_WAIT;
            end
         end
         ST_RD_WAIT: begin
            nak = nak_now;
            if (resp_valid) begin
               rx_capture = 1'b1;
               cnt_dec    = 1'b1;
               state_d    = nak_now ? ST_STOP_ISSUE : ST_RD_ISSUE;
            end
         end
         ST_STOP_ISSUE: begin
            cmd_valid = 1'b1;
            cmd_stop  = 1'b1;
            if (cmd_ready) begin
               state_d = ST_STOP_WAIT;
            end
         end
         ST_STOP_WAIT: begin
            if (resp_valid) begin
               cnt_clr = 1'b1;
               state_d = ST_FINISH;
            end
         end
         ST_FINISH: begin
            done    = 1'b1;
            state_d = ST_IDLE;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         abort_q <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         err_q   <= (state_q == ST_IDLE) && start && count_zero;
         if (state_q == ST_IDLE) begin
            abort_q <= 1'b0;
         end else if (abort && in_read_phase(state_q)) begin
            abort_q <= 1'b1;
         end
      end
   end

   assign busy     = (state_q != ST_IDLE);
   assign err_zero = err_q;

   AST_ZERO_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == ST_IDLE) && start && count_zero) |=> (!cmd_valid && !busy && err_zero)); // R5

   AST_STOP_AFTER_NAK: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == ST_RD_WAIT) && resp_valid && nak) |=> (cmd_valid && cmd_stop)); // R4

   AST_DONE_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == ST_STOP_WAIT) && resp_valid) |=> done); // R7

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R7

   AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      err_zero |=> !err_zero); // R5

endmodule

// File: rtl/i2c_burst_rx.sv
module i2c_burst_rx #(
   parameter int CNT_W      = 16,
   parameter int DATA_W     = 8,
   parameter bit ABORT_COMB = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [CNT_W-1:0]  count_i,
   input  logic              abort_i,
   output logic              be_cmd_valid_o,
   output logic              be_cmd_stop_o,
   output logic              be_nak_o,
   input  logic              be_cmd_ready_i,
   input  logic              be_resp_valid_i,
   input  logic [DATA_W-1:0] be_rdata_i,
   output logic [DATA_W-1:0] rx_data_o,
   output logic              rx_valid_o,
   input  logic              rx_ready_i,
   output logic              busy_o,
   output logic              done_o,
   output logic              err_zero_o,
   output logic [CNT_W-1:0]  remaining_o
);
   generate
      if (CNT_W > 32) begin : g_bad_cnt
         $error("i2c_burst_rx: CNT_W above 32 is not supported");
      end
      if (DATA_W != 8) begin : g_bad_data
         $error("i2c_burst_rx: I2C bytes are 8 bits wide");
      end
   endgenerate

   logic cnt_load, cnt_dec, cnt_clr, rem_last;
   logic rx_capture;
   logic count_zero;

   assign count_zero = (count_i == '0);

   i2cbr_counter #(.CNT_W(CNT_W)) u_counter (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (cnt_load),
      .load_val (count_i),
      .dec      (cnt_dec),
      .clr      (cnt_clr),
      .count    (remaining_o),
      .is_last  (rem_last)
   );

   i2cbr_rxbuf #(.DATA_W(DATA_W)) u_rxbuf (
      .clk      (clk),
      .rst_n    (rst_n),
      .capture  (rx_capture),
      .cap_data (be_rdata_i),
      .ready    (rx_ready_i),
      .valid    (rx_valid_o),
      .data     (rx_data_o)
   );

   i2cbr_seq #(.ABORT_COMB(ABORT_COMB)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start_i),
      .count_zero (count_zero),
      .abort      (abort_i),
      .cmd_ready  (be_cmd_ready_i),
      .resp_valid (be_resp_valid_i),
      .rem_last   (rem_last),
      .rx_full    (rx_valid_o),
      .cnt_load   (cnt_load),
      .cnt_dec    (cnt_dec),
      .cnt_clr    (cnt_clr),
      .cmd_valid  (be_cmd_valid_o),
      .cmd_stop   (be_cmd_stop_o),
      .nak        (be_nak_o),
      .rx_capture (rx_capture),
      .busy       (busy_o),
      .done       (done_o),
      .err_zero   (err_zero_o)
   );

   AST_DONE_REM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (remaining_o == '0)); // R7

   AST_NO_RD_WHILE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (be_cmd_valid_o && !be_cmd_stop_o) |-> !rx_valid_o); // R6

   AST_START_BUSY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i && !done_o && !cnt_dec && !cnt_clr) |=> $stable(remaining_o)); // R10

endmodule

// File: tb/i2c_burst_rx_tb.sv
module i2c_burst_rx_tb;
   localparam int CLK_PERIOD = 10;
   localparam int CNT_W      = 16;
   localparam int DATA_W     = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start_i = 1'b0;
   logic [CNT_W-1:0]  count_i = '0;
   logic              abort_i = 1'b0;
   logic              be_cmd_valid_o, be_cmd_stop_o, be_nak_o;
   logic              be_cmd_ready_i = 1'b0;
   logic              be_resp_valid_i = 1'b0;
   logic [DATA_W-1:0] be_rdata_i = '0;
   logic [DATA_W-1:0] rx_data_o;
   logic              rx_valid_o;
   logic              rx_ready_i = 1'b0;
   logic              busy_o, done_o, err_zero_o;
   logic [CNT_W-1:0]  remaining_o;

   always #(CLK_PERIOD/2) clk = ~clk;

   i2c_burst_rx #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .count_i(count_i), .abort_i(abort_i),
      .be_cmd_valid_o(be_cmd_valid_o), .be_cmd_stop_o(be_cmd_stop_o), .be_nak_o(be_nak_o),
      .be_cmd_ready_i(be_cmd_ready_i), .be_resp_valid_i(be_resp_valid_i), .be_rdata_i(be_rdata_i),
      .rx_data_o(rx_data_o), .rx_valid_o(rx_valid_o), .rx_ready_i(rx_ready_i),
      .busy_o(busy_o), .done_o(done_o), .err_zero_o(err_zero_o), .remaining_o(remaining_o)
   );

   int checks = 0;
   int errors = 0;

   // scoreboard state filled by the engine/consumer model
   logic [7:0] sent_q[$];
   bit         nak_hist[$];
   int  n_stops, n_delivered, order_bad, data_bad, stall_bad;
   int  done_seen, done_bad, rem_bad, err_seen, cmd_seen, busy_seen;
   int  rdy_pct = 100;
   bit  engine_on = 1'b0;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic clear_sb();
      sent_q.delete();
      nak_hist.delete();
      n_stops = 0; n_delivered = 0; order_bad = 0; data_bad = 0; stall_bad = 0;
      done_seen = 0; done_bad = 0; rem_bad = 0; err_seen = 0; cmd_seen = 0; busy_seen = 0;
   endtask

   function automatic int acks_ok(input int nread);
      int bad = 0;
      for (int i = 0; i < nread - 1; i++) if (nak_hist[i]) bad++;
      return bad;
   endfunction

   // bit engine and consumer model: drive at negedge, observe 1 time unit later
   initial begin
      bit         op_pending = 1'b0;
      bit         op_is_stop = 1'b0;
      int         op_timer = 0;
      bit         stop_prev = 1'b0;
      bit         hold_prev = 1'b0;
      logic [7:0] hold_data = '0;
      forever begin
         bit stop_now;
         bit was_pending;
         @(negedge clk);
         stop_now = 1'b0;
         be_resp_valid_i = 1'b0;
         rx_ready_i = (($urandom % 100) < rdy_pct);
         was_pending = op_pending;
         if (op_pending) begin
            be_cmd_ready_i = 1'b0;
            if (op_timer == 0) begin
               be_resp_valid_i = 1'b1;
               be_rdata_i = 8'($urandom);
            end else begin
               op_timer--;
            end
         end else begin
            be_cmd_ready_i = (($urandom % 3) != 0);
         end
         #1;
         if (engine_on) begin
            if (be_resp_valid_i) begin
               op_pending = 1'b0;
               if (!op_is_stop) begin
                  sent_q.push_back(be_rdata_i);
                  nak_hist.push_back(be_nak_o);
               end else begin
                  stop_now = 1'b1;
               end
            end
            if (be_cmd_valid_o) cmd_seen++;
            if (busy_o) busy_seen++;
            if (!was_pending && be_cmd_valid_o && be_cmd_ready_i) begin
               op_pending = 1'b1;
               op_is_stop = be_cmd_stop_o;
               op_timer = $urandom % 4;
               if (be_cmd_stop_o) begin
                  n_stops++;
                  if (nak_hist.size() == 0 || !nak_hist[nak_hist.size()-1]) order_bad++;
               end else begin
                  if (nak_hist.size() > 0 && nak_hist[nak_hist.size()-1]) order_bad++;
                  if (n_stops > 0) order_bad++;
               end
            end
            if (rx_valid_o && rx_ready_i) begin
               n_delivered++;
               if (sent_q.size() == 0) order_bad++;
               else if (sent_q.pop_front() != rx_data_o) data_bad++;
            end
            if (be_cmd_valid_o && !be_cmd_stop_o && rx_valid_o) stall_bad++;
            if (hold_prev && (!rx_valid_o || rx_data_o != hold_data)) stall_bad++;
            hold_prev = rx_valid_o && !rx_ready_i;
            hold_data = rx_data_o;
            if (done_o) begin
               done_seen++;
               if (!stop_prev) done_bad++;
               if (remaining_o != '0) rem_bad++;
            end else if (stop_prev) begin
               done_bad++;
            end
            if (err_zero_o) err_seen++;
            stop_prev = stop_now;
         end
      end
   end

   task automatic run_burst(input int n, input int abort_at, input int restart_at, input int pct, input string tag);
      int cyc = 0;
      clear_sb();
      rdy_pct = pct;
      @(negedge clk);
      start_i = 1'b1; count_i = CNT_W'(n);
      @(negedge clk);
      start_i = 1'b0; count_i = CNT_W'(n + 7);
      while (done_seen == 0 && cyc < 20000) begin
         abort_i = (cyc == abort_at);
         start_i = (cyc == restart_at);
         @(negedge clk);
         cyc++;
      end
      abort_i = 1'b0; start_i = 1'b0;
      check(done_seen == 1 && done_bad == 0, {tag, " R7 done one cycle after STOP"}, done_seen, 1);
      check(rem_bad == 0, {tag, " R7 remaining zero at done"}, rem_bad, 0);
      rdy_pct = 100;
      repeat (4) @(negedge clk);
      check(n_stops == 1 && order_bad == 0, {tag, " R4 single STOP right after NAK"}, n_stops, 1);
      check(stall_bad == 0, {tag, " R6 hold and stall"}, stall_bad, 0);
      check(data_bad == 0 && n_delivered == nak_hist.size(), {tag, " R1 bytes in order"}, n_delivered, nak_hist.size());
      if (abort_at < 0) begin
         check(nak_hist.size() == n, {tag, " R1/R10 byte count"}, nak_hist.size(), n);
         check(acks_ok(nak_hist.size()) == 0, {tag, " R2 ACK on non-final bytes"}, acks_ok(nak_hist.size()), 0);
         check(nak_hist.size() > 0 && nak_hist[nak_hist.size()-1], {tag, " R3 NAK on final byte"}, 0, 1);
      end else begin
         check(nak_hist.size() >= 1 && nak_hist.size() <= n, {tag, " R8 bytes within count"}, nak_hist.size(), n);
         check(acks_ok(nak_hist.size()) == 0 && nak_hist.size() > 0 && nak_hist[nak_hist.size()-1],
               {tag, " R8 only final byte NAKed"}, acks_ok(nak_hist.size()), 0);
      end
   endtask

   initial begin
      void'($urandom(32'd4711));
      // R9 reset state
      repeat (3) @(negedge clk);
      check(!be_cmd_valid_o && !rx_valid_o && !busy_o && !done_o && !err_zero_o && remaining_o == '0,
            "R9 outputs in reset", int'(busy_o), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!be_cmd_valid_o && !rx_valid_o && !busy_o && !done_o && !err_zero_o && remaining_o == '0,
            "R9 outputs after reset", int'(be_cmd_valid_o), 0);
      engine_on = 1'b1;

      // R5 zero count
      clear_sb();
      start_i = 1'b1; count_i = '0;
      @(negedge clk);
      start_i = 1'b0;
      #2;
      check(err_zero_o == 1'b1, "R5 error pulse after zero start", int'(err_zero_o), 1);
      repeat (10) @(negedge clk);
      check(err_seen == 1, "R5 error pulse lasts one cycle", err_seen, 1);
      check(cmd_seen == 0 && busy_seen == 0, "R5 no bus activity on zero count", cmd_seen, 0);

      // directed corners
      run_burst(1, -1, -1, 100, "single");
      run_burst(4, -1, -1, 5, "stalled");
      run_burst(10, 0, -1, 100, "abort-first");
      check(nak_hist.size() == 1, "R8 abort in first slot yields one byte", nak_hist.size(), 1);
      run_burst(6, -1, 3, 60, "restart-busy");
      run_burst(300, -1, -1, 100, "long");

      // constrained random bursts
      for (int k = 0; k < 25; k++) begin
         int n   = 1 + ($urandom % 12);
         int pct = 30 + ($urandom % 71);
         int ab  = (($urandom % 10) < 3) ? int'($urandom % (3 * n + 2)) : -1;
         int rs  = (($urandom % 10) < 3) ? int'($urandom % (2 * n + 2)) : -1;
         run_burst(n, ab, rs, pct, "random");
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 190000, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule